// File: doc/BRIEF.md
# Memory Request Address Format Checker

This block sits on the receive side of a PCI Express transaction path, after header parsing and before the application logic. Each incoming header is classified. Memory read and write requests are checked to see whether the header size they chose fits the address they carry. The rule is that an address below 4 GB must be sent with the short three-doubleword header and its 32-bit address. A request that uses the long four-doubleword header for such an address is an Unsupported Request. The block discards it, so the application side never sees it.

Each discarded request can raise a one-cycle report. The report carries the requester ID and tag of the offending request, so that the error-message logic can notify the Root Port. A configuration enable bit gates this report.

All other traffic, and all well-formed memory requests, pass through one registered output stage unchanged. Both sides use a valid/ready handshake. A request that is discarded is taken from the input at once, even while the output is stalled.

Top module: `tlp_addr_fmt_chk`

## Requirements
- R1: While reset is asserted and after its release, out_valid and ur_strobe are 0 until a header is accepted.
- R2: A memory request is a header with in_fmt[2]=0 and in_type[4:1]=4'b0000. A memory request with in_fmt[0]=0 (three-doubleword header) is accepted and appears unchanged on the out_* fields, with out_valid high, in the cycle after acceptance.
- R3: A memory request with in_fmt[0]=1 and a nonzero in_addr_hi is forwarded unchanged, in the same way as in R2.
- R4: A memory request with in_fmt[0]=1 and in_addr_hi equal to zero is accepted but never appears on the output.
- R5: When a request is dropped under R4 and err_msg_en is 1 in its acceptance cycle, ur_strobe is high for exactly the next cycle. In that cycle ur_req_id and ur_tag hold the dropped request's requester ID and tag.
- R6: When a request is dropped under R4 and err_msg_en is 0, ur_strobe stays low.
- R7: A header that is not a memory request (in_fmt[2]=1 or in_type[4:1]≠0) is forwarded unchanged whatever its in_fmt[0] and address.
- R8: While out_valid is high and out_ready is low, the out_* fields hold their values. For a header that would be forwarded, in_ready is low in this state.
- R9: A header that would be dropped under R4 sees in_ready high, even while the output is stalled.
- R10: With out_ready held high, one forwarded header is accepted and delivered every cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_msg_en | input | 1 | Enables the drop report |
| in_valid | input | 1 | Input header valid |
| in_ready | output | 1 | Input header accepted this cycle when in_valid is high |
| in_fmt | input | 3 | Header format field; bit 0 selects the four-doubleword header |
| in_type | input | 5 | Header type field |
| in_addr_hi | input | ADDR_HI_W | Upper address word (zero for short headers) |
| in_addr_lo | input | ADDR_LO_W | Lower address word |
| in_req_id | input | RID_W | Requester ID |
| in_tag | input | TAG_W | Transaction tag |
| out_valid | output | 1 | Forwarded header valid |
| out_ready | input | 1 | Application side can take the header |
| out_fmt | output | 3 | Forwarded format field |
| out_type | output | 5 | Forwarded type field |
| out_addr_hi | output | ADDR_HI_W | Forwarded upper address word |
| out_addr_lo | output | ADDR_LO_W | Forwarded lower address word |
| out_req_id | output | RID_W | Forwarded requester ID |
| out_tag | output | TAG_W | Forwarded tag |
| ur_strobe | output | 1 | One-cycle report of a dropped request |
| ur_req_id | output | RID_W | Requester ID of the dropped request |
| ur_tag | output | TAG_W | Tag of the dropped request |

## Verification
The properties assume that the header fields are stable and defined whenever in_valid is high. They also assume that in_valid and err_msg_en hold known values from reset onward, because acceptance and the report both sample them on the accepting edge. The stimulus drives every input only on the falling clock edge and holds it for the full cycle, starting from all-zero values under reset. The upper address word is zero in roughly half of the four-doubleword headers, so that both branches of the 4 GB test occur often under random back-pressure.

// File: rtl/tlp_chk_pkg.sv
package tlp_chk_pkg;

  localparam int FMT_W  = 3;
  localparam int TYPE_W = 5;

  // bit positions inside the format field that the decode depends on
  localparam int FMT_BIT_4DW    = 0;
  localparam int FMT_BIT_PREFIX = 2;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,  // not a memory request: no address check
    CLS_MEM_OK = 2'd1,  // memory request with a consistent header size
    CLS_MEM_UR = 2'd2   // long header for an address that fits in 32 bits
  } req_cls_e;

endpackage

// File: rtl/tlp_hdr_classify.sv
module tlp_hdr_classify
  import tlp_chk_pkg::*;
#(
  parameter int ADDR_HI_W = 32
) (
  input  logic [FMT_W-1:0]     fmt,
  input  logic [TYPE_W-1:0]    kind,
  input  logic [ADDR_HI_W-1:0] addr_hi,
  output req_cls_e             cls
);

  logic is_mem;
  logic is_long;
  logic hi_zero;
  logic unused_bits;

  // memory read, write and locked read share type[4:1] = 0
  assign is_mem      = ~fmt[FMT_BIT_PREFIX] & (kind[TYPE_W-1:1] == '0);
  assign is_long     = fmt[FMT_BIT_4DW];
  assign hi_zero     = ~|addr_hi;
  assign unused_bits = fmt[1] ^ kind[0];

  always_comb begin
    if (!is_mem) begin
      cls = CLS_OTHER;
    end else if (is_long && hi_zero) begin
      cls = CLS_MEM_UR;
    end else begin
      cls = CLS_MEM_OK;
    end
  end

endmodule

// File: rtl/tlp_fwd_stage.sv
module tlp_fwd_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              valid_q;
  logic              valid_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  assign can_load = ~valid_q | out_ready;
  assign data_en  = load;

  always_comb begin
    valid_d = valid_q;
    if (load) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // payload register carries no reset; it is qualified by valid_q
  always_ff @(posedge clk) begin
    if (data_en) begin
      data_q <= load_data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

endmodule

// File: rtl/tlp_ur_report.sv
module tlp_ur_report #(
  parameter int RID_W = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             enable,
  input  logic [RID_W-1:0] rid_in,
  input  logic [TAG_W-1:0] tag_in,
  output logic             strobe,
  output logic [RID_W-1:0] rid_out,
  output logic [TAG_W-1:0] tag_out
);

  logic             strobe_q;
  logic             strobe_d;
  logic             info_en;
  logic [RID_W-1:0] rid_q;
  logic [TAG_W-1:0] tag_q;

  assign strobe_d = fire & enable;
  assign info_en  = strobe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (info_en) begin
      rid_q <= rid_in;
      tag_q <= tag_in;
    end
  end

  assign strobe  = strobe_q;
  assign rid_out = rid_q;
  assign tag_out = tag_q;

endmodule

// File: rtl/tlp_addr_fmt_chk.sv
module tlp_addr_fmt_chk
  import tlp_chk_pkg::*;
#(
  parameter int ADDR_HI_W = 32,
  parameter int ADDR_LO_W = 32,
  parameter int RID_W     = 16,
  parameter int TAG_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_msg_en,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_fmt,
  input  logic [4:0]           in_type,
  input  logic [ADDR_HI_W-1:0] in_addr_hi,
  input  logic [ADDR_LO_W-1:0] in_addr_lo,
  input  logic [RID_W-1:0]     in_req_id,
  input  logic [TAG_W-1:0]     in_tag,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2:0]           out_fmt,
  output logic [4:0]           out_type,
  output logic [ADDR_HI_W-1:0] out_addr_hi,
  output logic [ADDR_LO_W-1:0] out_addr_lo,
  output logic [RID_W-1:0]     out_req_id,
  output logic [TAG_W-1:0]     out_tag,
  output logic                 ur_strobe,
  output logic [RID_W-1:0]     ur_req_id,
  output logic [TAG_W-1:0]     ur_tag
);

  localparam int HDR_W = FMT_W + TYPE_W + ADDR_HI_W + ADDR_LO_W + RID_W + TAG_W;

  req_cls_e         cls;
  logic             drop;
  logic             accept;
  logic             load;
  logic             fwd_can_load;
  logic [HDR_W-1:0] hdr_in;
  logic [HDR_W-1:0] hdr_out;

  tlp_hdr_classify #(
    .ADDR_HI_W (ADDR_HI_W)
  ) u_classify (
    .fmt     (in_fmt),
    .kind    (in_type),
    .addr_hi (in_addr_hi),
    .cls     (cls)
  );

  // a header to be dropped never needs the output register
  assign drop     = in_valid & (cls == CLS_MEM_UR);
  assign in_ready = drop | fwd_can_load;
  assign accept   = in_valid & in_ready;
  assign load     = accept & ~drop;

  assign hdr_in = {in_fmt, in_type, in_addr_hi, in_addr_lo, in_req_id, in_tag};

  tlp_fwd_stage #(
    .DATA_W (HDR_W)
  ) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (hdr_in),
    .can_load  (fwd_can_load),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (hdr_out)
  );

  assign {out_fmt, out_type, out_addr_hi, out_addr_lo, out_req_id, out_tag} = hdr_out;

  tlp_ur_report #(
    .RID_W (RID_W),
    .TAG_W (TAG_W)
  ) u_report (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (accept & drop),
    .enable  (err_msg_en),
    .rid_in  (in_req_id),
    .tag_in  (in_tag),
    .strobe  (ur_strobe),
    .rid_out (ur_req_id),
    .tag_out (ur_tag)
  );

endmodule

// File: rtl/tlp_addr_fmt_chk_sva.sv
module tlp_addr_fmt_chk_sva #(
  parameter int ADDR_HI_W = 32,
  parameter int ADDR_LO_W = 32,
  parameter int RID_W     = 16,
  parameter int TAG_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 err_msg_en,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [2:0]           in_fmt,
  input logic [4:0]           in_type,
  input logic [ADDR_HI_W-1:0] in_addr_hi,
  input logic [ADDR_LO_W-1:0] in_addr_lo,
  input logic [RID_W-1:0]     in_req_id,
  input logic [TAG_W-1:0]     in_tag,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [ADDR_HI_W-1:0] out_addr_hi,
  input logic [ADDR_LO_W-1:0] out_addr_lo,
  input logic [RID_W-1:0]     out_req_id,
  input logic [TAG_W-1:0]     out_tag,
  input logic                 ur_strobe,
  input logic [RID_W-1:0]     ur_req_id,
  input logic [TAG_W-1:0]     ur_tag
);

  logic acc;
  logic bad;

  assign acc = in_valid & in_ready;
  assign bad = ~in_fmt[2] & (in_type[4:1] == 4'b0000) & in_fmt[0] & (in_addr_hi == '0);

  assert_fwd_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !bad |=> out_valid && out_tag == $past(in_tag) && out_addr_lo == $past(in_addr_lo)
                    && out_req_id == $past(in_req_id));

  assert_drop_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad && (!out_valid || out_ready) |=> !out_valid);

  assert_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad && err_msg_en |=> ur_strobe && ur_req_id == $past(in_req_id) && ur_tag == $past(in_tag));

  assert_report_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ur_strobe |-> $past(in_valid && in_ready));

  assert_report_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad && !err_msg_en |=> !ur_strobe);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_addr_hi)
                                && $stable(out_addr_lo) && $stable(out_req_id));

  assert_drop_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && bad |-> in_ready);

endmodule

bind tlp_addr_fmt_chk tlp_addr_fmt_chk_sva #(
  .ADDR_HI_W (ADDR_HI_W),
  .ADDR_LO_W (ADDR_LO_W),
  .RID_W     (RID_W),
  .TAG_W     (TAG_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_msg_en  (err_msg_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_fmt      (in_fmt),
  .in_type     (in_type),
  .in_addr_hi  (in_addr_hi),
  .in_addr_lo  (in_addr_lo),
  .in_req_id   (in_req_id),
  .in_tag      (in_tag),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr_hi (out_addr_hi),
  .out_addr_lo (out_addr_lo),
  .out_req_id  (out_req_id),
  .out_tag     (out_tag),
  .ur_strobe   (ur_strobe),
  .ur_req_id   (ur_req_id),
  .ur_tag      (ur_tag)
);

// File: tb/tb_tlp_addr_fmt_chk.sv
module tb_tlp_addr_fmt_chk;

  logic        clk;
  logic        rst_n;
  logic        err_msg_en;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_fmt;
  logic [4:0]  in_type;
  logic [31:0] in_addr_hi;
  logic [31:0] in_addr_lo;
  logic [15:0] in_req_id;
  logic [7:0]  in_tag;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_fmt;
  logic [4:0]  out_type;
  logic [31:0] out_addr_hi;
  logic [31:0] out_addr_lo;
  logic [15:0] out_req_id;
  logic [7:0]  out_tag;
  logic        ur_strobe;
  logic [15:0] ur_req_id;
  logic [7:0]  ur_tag;

  tlp_addr_fmt_chk dut (
    .clk(clk), .rst_n(rst_n), .err_msg_en(err_msg_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_fmt(in_fmt), .in_type(in_type),
    .in_addr_hi(in_addr_hi), .in_addr_lo(in_addr_lo), .in_req_id(in_req_id), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt), .out_type(out_type),
    .out_addr_hi(out_addr_hi), .out_addr_lo(out_addr_lo), .out_req_id(out_req_id),
    .out_tag(out_tag), .ur_strobe(ur_strobe), .ur_req_id(ur_req_id), .ur_tag(ur_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  logic [95:0] exp_q[$];
  logic        m_str = 1'b0;
  logic [15:0] m_rid = '0;
  logic [7:0]  m_tag = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic v, input logic [2:0] f, input logic [4:0] t,
                                input logic [31:0] hi);
    return v && !f[2] && (t[4:1] == 4'b0000) && f[0] && (hi == 32'd0);
  endfunction

  // behavioural reference: one expected-output queue and one expected report
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      m_str = 1'b0;
    end else begin
      bit bad;
      bit rdy;
      bit acc;
      bad = is_bad(in_valid, in_fmt, in_type, in_addr_hi);
      rdy = bad || exp_q.size() == 0 || out_ready;
      acc = in_valid && rdy;
      if (exp_q.size() > 0 && out_ready) void'(exp_q.pop_front());
      if (acc && !bad) exp_q.push_back({in_fmt, in_type, in_addr_hi, in_addr_lo, in_req_id, in_tag});
      m_str = acc && bad && err_msg_en;
      if (m_str) begin
        m_rid = in_req_id;
        m_tag = in_tag;
      end
      #1;
      chk(out_valid == (exp_q.size() > 0), cur_req, "out_valid", 96'(out_valid), 96'(exp_q.size() > 0));
      if (out_valid && exp_q.size() > 0)
        chk({out_fmt, out_type, out_addr_hi, out_addr_lo, out_req_id, out_tag} == exp_q[0],
            cur_req, "out header", {out_fmt, out_type, out_addr_hi, out_addr_lo, out_req_id, out_tag},
            exp_q[0]);
      chk(ur_strobe == m_str, cur_req, "ur_strobe", 96'(ur_strobe), 96'(m_str));
      if (ur_strobe && m_str)
        chk({ur_req_id, ur_tag} == {m_rid, m_tag}, cur_req, "ur id/tag",
            96'({ur_req_id, ur_tag}), 96'({m_rid, m_tag}));
    end
  end

  task automatic drive(input logic v, input logic [2:0] f, input logic [4:0] t,
                       input logic [31:0] hi, input logic [31:0] lo, input logic [15:0] rid,
                       input logic [7:0] tg, input logic en, input logic ordy);
    bit exp_rdy;
    @(negedge clk);
    in_valid = v; in_fmt = f; in_type = t; in_addr_hi = hi; in_addr_lo = lo;
    in_req_id = rid; in_tag = tg; err_msg_en = en; out_ready = ordy;
    #1;
    exp_rdy = is_bad(v, f, t, hi) || exp_q.size() == 0 || ordy;
    chk(in_ready == exp_rdy, cur_req, "in_ready", 96'(in_ready), 96'(exp_rdy));
  endtask

  task automatic idle(input logic ordy);
    drive(1'b0, 3'b000, 5'b00000, 32'd0, 32'd0, 16'd0, 8'd0, 1'b0, ordy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; err_msg_en = 1'b0; in_valid = 1'b0; in_fmt = '0; in_type = '0;
    in_addr_hi = '0; in_addr_lo = '0; in_req_id = '0; in_tag = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    cur_req = "R1";
    chk(out_valid == 1'b0, "R1", "out_valid in reset", 96'(out_valid), 96'd0);
    chk(ur_strobe == 1'b0, "R1", "ur_strobe in reset", 96'(ur_strobe), 96'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1'b1);
    idle(1'b1);

    cur_req = "R2";  // short-header write and read
    drive(1'b1, 3'b010, 5'b00000, 32'd0, 32'h0000_1000, 16'h0101, 8'h01, 1'b1, 1'b1);
    drive(1'b1, 3'b000, 5'b00000, 32'd0, 32'hFFFF_FFFC, 16'h0102, 8'h02, 1'b1, 1'b1);
    idle(1'b1);

    cur_req = "R3";  // long header above 4 GB, including the lowest such address
    drive(1'b1, 3'b011, 5'b00000, 32'h0000_0001, 32'h0, 16'h0201, 8'h11, 1'b1, 1'b1);
    drive(1'b1, 3'b001, 5'b00001, 32'h8000_0000, 32'h40, 16'h0202, 8'h12, 1'b1, 1'b1);
    idle(1'b1);

    cur_req = "R4";  // long header below 4 GB is dropped, report disabled (also R6)
    drive(1'b1, 3'b001, 5'b00000, 32'd0, 32'h2000, 16'h0301, 8'h21, 1'b0, 1'b1);
    idle(1'b1);
    cur_req = "R6";
    drive(1'b1, 3'b011, 5'b00000, 32'd0, 32'hFFFF_FFFF, 16'h0302, 8'h22, 1'b0, 1'b1);
    idle(1'b1);

    cur_req = "R5";  // report enabled, then back-to-back drops
    drive(1'b1, 3'b011, 5'b00000, 32'd0, 32'h3000, 16'hABCD, 8'h5A, 1'b1, 1'b1);
    drive(1'b1, 3'b001, 5'b00001, 32'd0, 32'h3004, 16'h1234, 8'hA5, 1'b1, 1'b1);
    idle(1'b1);
    idle(1'b1);

    cur_req = "R7";  // non-memory headers: completion, message, prefixed header
    drive(1'b1, 3'b001, 5'b01010, 32'd0, 32'h10, 16'h0401, 8'h31, 1'b1, 1'b1);
    drive(1'b1, 3'b001, 5'b10000, 32'd0, 32'h14, 16'h0402, 8'h32, 1'b1, 1'b1);
    drive(1'b1, 3'b101, 5'b00000, 32'd0, 32'h18, 16'h0403, 8'h33, 1'b1, 1'b1);
    idle(1'b1);

    cur_req = "R8";  // stall with a held header, then another legal header waits
    drive(1'b1, 3'b000, 5'b00000, 32'd0, 32'h500, 16'h0501, 8'h41, 1'b1, 1'b0);
    drive(1'b1, 3'b010, 5'b00000, 32'd0, 32'h504, 16'h0502, 8'h42, 1'b1, 1'b0);
    drive(1'b1, 3'b010, 5'b00000, 32'd0, 32'h504, 16'h0502, 8'h42, 1'b1, 1'b0);

    cur_req = "R9";  // drop accepted while the output stays stalled
    drive(1'b1, 3'b001, 5'b00000, 32'd0, 32'h600, 16'h0601, 8'h51, 1'b1, 1'b0);
    idle(1'b0);
    idle(1'b1);
    idle(1'b1);

    cur_req = "R10";  // streaming without bubbles
    for (int i = 0; i < 8; i++)
      drive(1'b1, 3'b010, 5'b00000, 32'd0, 32'(i * 4), 16'(16'h0700 + i), 8'(i), 1'b1, 1'b1);
    idle(1'b1);

    cur_req = "R2 R4 R8 random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [2:0]  f;
      logic [4:0]  t;
      r = $urandom;
      f = (r[3:0] == 4'd0) ? 3'b101 : {1'b0, r[5], r[4]};
      t = (r[7:6] == 2'd0) ? 5'b01010 : {4'b0000, r[8]};
      drive(r[9] | r[10], f, t, r[11] ? 32'd0 : $urandom, $urandom, 16'($urandom),
            8'($urandom), r[12], r[13] | r[14]);
    end
    idle(1'b1);
    idle(1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule